// File: doc/BRIEF.md
# Three-Channel Oversampled Serial Receive Capture

This block is the receive front end for three serial input lines. A shared sample strobe marks each oversampling instant. On every strobe, each enabled channel shifts the level of its line into a shift register. After eight strobes the channel has one bit period of line samples, and it hands that byte to a processor.

Each channel holds its latest byte together with two sticky flags. The ready flag says a new byte is waiting. The overrun flag says a byte arrived while the previous one was still unread. The processor clears either flag by pulsing a clear input for that flag.

A per-channel frame length limits how many bit periods the channel captures. When the last of them is complete, the channel emits a one-cycle completion pulse, so a clock unit can stop the line clock. The channel then stays idle until it is disabled and enabled again.

Dropping a channel's enable wipes all of that channel's state. The three data bytes and the six flags are reported in one 32-bit status word. While the transmit side is active, the low 24 bits of that word carry transmit status instead of receive data.

Top module: `ovs_rx_capture`

## Requirements
- R1: Sampling happens only on cycles where `sample_en_i` is high and the channel is enabled and not finished. Eight samples form one byte, and the first sample of a bit period lands in bit 7. Channel 0's byte is in `status_o[7:0]`, channel 1's in `[15:8]` and channel 2's in `[23:16]`. Each byte appears at the clock edge that takes its eighth sample.
- R2: The ready flag of channel i is `status_o[24+i]`. It is set at the edge that completes a byte. It stays set until a cycle in which `clr_valid_i[i]` is high.
- R3: The overrun flag of channel i is `status_o[27+i]`. It is set when a byte completes while the ready flag is 1 and is not being cleared in that cycle. It is cleared by `clr_ovf_i[i]`. The data lane always holds the newest byte.
- R4: When a flag is set and cleared in the same cycle, the flag ends up set.
- R5: While `rx_enable_i[i]` is 0, channel i's samples, bit count, byte, flags and finished state are held at zero.
- R6: Channel i's frame length is `frame_len_i[8*i+7:8*i]`. If it is N (nonzero), the Nth completed byte raises `frame_done_o[i]` for exactly one cycle, and after that the channel takes no more samples. A length of 0 means capture never stops.
- R7: While `tx_active_i` is 1, `status_o[23:0]` equals `tx_lane_i`, and the flags in `[29:24]` stay visible. Bits `[31:30]` are always 0.
- R8: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line_i | input | 3 | Serial input line per channel |
| sample_en_i | input | 1 | Oversampling strobe shared by all channels |
| rx_enable_i | input | 3 | Per-channel enable; 0 wipes that channel |
| frame_len_i | input | 24 | Per-channel frame length in bit periods, 8 bits each, 0 means unlimited |
| clr_valid_i | input | 3 | Clear pulse for each ready flag |
| clr_ovf_i | input | 3 | Clear pulse for each overrun flag |
| tx_active_i | input | 1 | Transmit active; selects transmit status onto the low lanes |
| tx_lane_i | input | 24 | Transmit status shown while transmit is active |
| status_o | output | 32 | Packed bytes, ready flags and overrun flags |
| frame_done_o | output | 3 | One-cycle pulse when a channel's frame completes |

## Verification
The hardest situations to reach from the ports involve the byte-completion edge coinciding with something else. One is a byte completing in the same cycle as a clear of the ready or overrun flag. Another is a frame completing just as the enable drops. Both need the sample counter aligned to within one strobe.

The bench gets there in two ways. A long run drives the strobe, the lines, the clears and rare enable drops from a fixed-seed random source, with short frame lengths so completions are frequent. Directed sequences then count strobes exactly to place a clear on the completing edge.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;
  localparam int unsigned NUM_CH    = 3;
  localparam int unsigned SAMPLES   = 8;
  localparam int unsigned LEN_W     = 8;
  localparam int unsigned STATUS_W  = 32;
  localparam int unsigned LANES_W   = NUM_CH * SAMPLES;
  localparam int unsigned RDY_BASE  = LANES_W;
  localparam int unsigned OVR_BASE  = LANES_W + NUM_CH;
  localparam int unsigned PAD_W     = STATUS_W - OVR_BASE - NUM_CH;

  typedef struct packed {
    logic               ovr;
    logic               rdy;
    logic [SAMPLES-1:0] data;
  } lane_view_t;
endpackage

// File: rtl/ovs_rx_w1c.sv
module ovs_rx_w1c (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_d;

  always_comb begin
    if (!en) q_d = 1'b0;
    else     q_d = set | (q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  // R4: a set event wins over a simultaneous clear
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && set) |=> q);
  // R2 / R3: a lone clear drops the flag
  assert_clear_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
endmodule

// File: rtl/ovs_rx_sampler.sv
module ovs_rx_sampler #(
  parameter int unsigned OVS   = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sample_en,
  input  logic             line,
  input  logic [CNT_W-1:0] frame_len,
  output logic             byte_evt,
  output logic [OVS-1:0]   byte_data,
  output logic             frame_done
);
  localparam int unsigned SCNT_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SCNT_W-1:0] LAST_SAMPLE = SCNT_W'(OVS - 1);

  logic [OVS-1:0]    sh_q, sh_d;
  logic [SCNT_W-1:0] scnt_q, scnt_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic              done_q, done_d;
  logic              fdone_q, fdone_d;
  logic              take, hit;

  always_comb begin
    take      = en & sample_en & ~done_q;
    byte_data = {sh_q[OVS-2:0], line};
    byte_evt  = take & (scnt_q == LAST_SAMPLE);
    hit       = byte_evt & (frame_len != '0) & (CNT_W'(bcnt_q + 1'b1) == frame_len);
  end

  always_comb begin
    sh_d    = sh_q;
    scnt_d  = scnt_q;
    bcnt_d  = bcnt_q;
    done_d  = done_q | hit;
    fdone_d = hit;
    if (take) begin
      sh_d   = byte_data;
      scnt_d = byte_evt ? '0 : SCNT_W'(scnt_q + 1'b1);
    end
    if (byte_evt) bcnt_d = CNT_W'(bcnt_q + 1'b1);
    if (!en) begin
      sh_d    = '0;
      scnt_d  = '0;
      bcnt_d  = '0;
      done_d  = 1'b0;
      fdone_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      scnt_q  <= '0;
      bcnt_q  <= '0;
      done_q  <= 1'b0;
      fdone_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      scnt_q  <= scnt_d;
      bcnt_q  <= bcnt_d;
      done_q  <= done_d;
      fdone_q <= fdone_d;
    end
  end

  assign frame_done = fdone_q;

  // R6: the completion indication lasts one cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  // R6: a finished channel no longer moves its sample counter
  assert_done_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && en) |=> $stable(scnt_q));
  // R1: without a strobe the sample position holds
  assert_strobe_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_en && en) |=> $stable(scnt_q));
endmodule

// File: rtl/ovs_rx_lane.sv
module ovs_rx_lane
  import ovs_rx_pkg::*;
#(
  parameter int unsigned OVS   = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sample_en,
  input  logic             line,
  input  logic [CNT_W-1:0] frame_len,
  input  logic             clr_rdy,
  input  logic             clr_ovr,
  output logic [OVS-1:0]   data,
  output logic             rdy,
  output logic             ovr,
  output logic             frame_done
);
  logic           byte_evt;
  logic [OVS-1:0] byte_data;
  logic [OVS-1:0] data_d;
  logic           ovr_set;

  ovs_rx_sampler #(.OVS(OVS), .CNT_W(CNT_W)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .sample_en  (sample_en),
    .line       (line),
    .frame_len  (frame_len),
    .byte_evt   (byte_evt),
    .byte_data  (byte_data),
    .frame_done (frame_done)
  );

  always_comb begin
    ovr_set = byte_evt & rdy & ~clr_rdy;
    if (!en)           data_d = '0;
    else if (byte_evt) data_d = byte_data;
    else               data_d = data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data <= '0;
    else        data <= data_d;
  end

  ovs_rx_w1c u_rdy (
    .clk (clk), .rst_n (rst_n), .en (en),
    .set (byte_evt), .clr (clr_rdy), .q (rdy)
  );

  ovs_rx_w1c u_ovr (
    .clk (clk), .rst_n (rst_n), .en (en),
    .set (ovr_set), .clr (clr_ovr), .q (ovr)
  );

  // R5: a disabled channel shows no byte and no flags
  assert_disable_wipes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (data == '0 && !rdy && !ovr));
  // R3: an overrun only appears with the ready flag standing
  assert_ovr_with_rdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> rdy);
endmodule

// File: rtl/ovs_rx_capture.sv
module ovs_rx_capture
  import ovs_rx_pkg::*;
#(
  parameter int unsigned CNT_W = LEN_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         rx_line_i,
  input  logic                      sample_en_i,
  input  logic [NUM_CH-1:0]         rx_enable_i,
  input  logic [NUM_CH*CNT_W-1:0]   frame_len_i,
  input  logic [NUM_CH-1:0]         clr_valid_i,
  input  logic [NUM_CH-1:0]         clr_ovf_i,
  input  logic                      tx_active_i,
  input  logic [LANES_W-1:0]        tx_lane_i,
  output logic [STATUS_W-1:0]       status_o,
  output logic [NUM_CH-1:0]         frame_done_o
);
  lane_view_t [NUM_CH-1:0] view;
  logic [LANES_W-1:0]      rx_lanes;
  logic [NUM_CH-1:0]       rdy_vec, ovr_vec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ovs_rx_lane #(.OVS(SAMPLES), .CNT_W(CNT_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (rx_enable_i[c]),
      .sample_en  (sample_en_i),
      .line       (rx_line_i[c]),
      .frame_len  (frame_len_i[c*CNT_W +: CNT_W]),
      .clr_rdy    (clr_valid_i[c]),
      .clr_ovr    (clr_ovf_i[c]),
      .data       (view[c].data),
      .rdy        (view[c].rdy),
      .ovr        (view[c].ovr),
      .frame_done (frame_done_o[c])
    );
    assign rx_lanes[c*SAMPLES +: SAMPLES] = view[c].data;
    assign rdy_vec[c] = view[c].rdy;
    assign ovr_vec[c] = view[c].ovr;
  end

  always_comb begin
    status_o = {{PAD_W{1'b0}}, ovr_vec, rdy_vec,
                (tx_active_i ? tx_lane_i : rx_lanes)};
  end

  // R8: nothing is reported out of reset
  assert_reset_quiet_R8: assert property (@(posedge clk)
    !rst_n |=> (status_o[OVR_BASE+NUM_CH-1:RDY_BASE] == '0 && frame_done_o == '0));
endmodule

// File: tb/test_ovs_rx_capture.sv
`timescale 1ns/1ps
module test_ovs_rx_capture;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  rx_line_i, rx_enable_i, clr_valid_i, clr_ovf_i;
  logic        sample_en_i, tx_active_i;
  logic [23:0] frame_len_i, tx_lane_i;
  logic [31:0] status_o;
  logic [2:0]  frame_done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  ovs_rx_capture i_ovs_rx_capture (
    .clk(clk), .rst_n(rst_n), .rx_line_i(rx_line_i), .sample_en_i(sample_en_i),
    .rx_enable_i(rx_enable_i), .frame_len_i(frame_len_i),
    .clr_valid_i(clr_valid_i), .clr_ovf_i(clr_ovf_i),
    .tx_active_i(tx_active_i), .tx_lane_i(tx_lane_i),
    .status_o(status_o), .frame_done_o(frame_done_o)
  );

  always #4 clk = ~clk;

  // reference state
  logic [7:0] m_sh[NCH], m_data[NCH], m_bcnt[NCH];
  int         m_scnt[NCH];
  logic       m_rdy[NCH], m_ovr[NCH], m_done[NCH], m_fd[NCH];

  function automatic logic [31:0] exp_status();
    logic [31:0] s;
    s = '0;
    for (int c = 0; c < NCH; c++) begin
      s[8*c +: 8] = m_data[c];
      s[24+c]     = m_rdy[c];
      s[27+c]     = m_ovr[c];
    end
    if (tx_active_i) s[23:0] = tx_lane_i;
    return s;
  endfunction

  function automatic logic [2:0] exp_done();
    return {m_fd[2], m_fd[1], m_fd[0]};
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_sh[c] = 0; m_data[c] = 0; m_bcnt[c] = 0; m_scnt[c] = 0;
      m_rdy[c] = 0; m_ovr[c] = 0; m_done[c] = 0; m_fd[c] = 0;
    end
  endtask

  task automatic model_edge();
    for (int c = 0; c < NCH; c++) begin
      logic evt, hit;
      logic [7:0] b;
      evt = 0; hit = 0; b = {m_sh[c][6:0], rx_line_i[c]};
      if (!rx_enable_i[c]) begin
        m_sh[c] = 0; m_data[c] = 0; m_bcnt[c] = 0; m_scnt[c] = 0;
        m_rdy[c] = 0; m_ovr[c] = 0; m_done[c] = 0; m_fd[c] = 0;
      end else begin
        if (sample_en_i && !m_done[c]) begin
          m_sh[c] = b;
          if (m_scnt[c] == 7) begin
            evt = 1; m_scnt[c] = 0;
            if (frame_len_i[8*c +: 8] != 0 && 8'(m_bcnt[c] + 1) == frame_len_i[8*c +: 8]) hit = 1;
            m_bcnt[c] = 8'(m_bcnt[c] + 1);
          end else m_scnt[c]++;
        end
        m_ovr[c] = (evt && m_rdy[c] && !clr_valid_i[c]) || (m_ovr[c] && !clr_ovf_i[c]);
        m_rdy[c] = evt || (m_rdy[c] && !clr_valid_i[c]);
        if (evt) m_data[c] = b;
        if (hit) m_done[c] = 1;
        m_fd[c] = hit;
      end
    end
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [31:0] e;
    e = exp_status();
    chk("R1 lanes", {8'h0, status_o[23:0]}, {8'h0, e[23:0]});
    chk("R2 ready", {29'h0, status_o[26:24]}, {29'h0, e[26:24]});
    chk("R3 overrun", {29'h0, status_o[29:27]}, {29'h0, e[29:27]});
    chk("R7 pad", {30'h0, status_o[31:30]}, 32'h0);
    chk("R6 done", {29'h0, frame_done_o}, {29'h0, exp_done()});
  endtask

  // one clock: inputs already applied at negedge
  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    rx_line_i = 0; sample_en_i = 0; clr_valid_i = 0; clr_ovf_i = 0;
    tx_active_i = 0; tx_lane_i = 0;
  endtask

  // send one byte on channel c with strobe every cycle
  task automatic send_byte(int c, logic [7:0] v);
    for (int k = 7; k >= 0; k--) begin
      sample_en_i = 1; rx_line_i[c] = v[k];
      tick();
    end
    sample_en_i = 0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 0; idle_inputs(); rx_enable_i = 0; frame_len_i = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R8 status", status_o, 32'h0);
    chk("R8 done", {29'h0, frame_done_o}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R1: directed byte, MSB-first sample order
    rx_enable_i = 3'b001;
    send_byte(0, 8'hA5);
    chk("R1 byte", {24'h0, status_o[7:0]}, 32'hA5);
    chk("R2 set", {31'h0, status_o[24]}, 32'h1);
    // R7: transmit status takes the lanes, flags stay
    tx_active_i = 1; tx_lane_i = 24'h5A_C3_3C;
    #1;
    chk("R7 mux", {8'h0, status_o[23:0]}, 32'h5A_C3_3C);
    chk("R7 flags", {31'h0, status_o[24]}, 32'h1);
    tx_active_i = 0;
    // R3: second byte while ready -> overrun, newest data
    send_byte(0, 8'h3C);
    chk("R3 ovr", {31'h0, status_o[27]}, 32'h1);
    chk("R3 newest", {24'h0, status_o[7:0]}, 32'h3C);
    // R4: clear ready on completing edge -> stays set, no new overrun
    clr_ovf_i[0] = 1; tick(); clr_ovf_i[0] = 0;
    chk("R3 clear", {31'h0, status_o[27]}, 32'h0);
    for (int k = 7; k >= 0; k--) begin
      sample_en_i = 1; rx_line_i[0] = k[0];
      clr_valid_i[0] = (k == 0);
      tick();
    end
    sample_en_i = 0; clr_valid_i = 0;
    chk("R4 set wins", {31'h0, status_o[24]}, 32'h1);
    chk("R4 no ovr", {31'h0, status_o[27]}, 32'h0);
    clr_valid_i[0] = 1; tick(); clr_valid_i[0] = 0;
    chk("R2 clear", {31'h0, status_o[24]}, 32'h0);
    // R5: disable wipes
    rx_enable_i = 0; tick();
    chk("R5 wipe", status_o, 32'h0);
    // R6: frame of 2 bytes on channel 1
    frame_len_i = 24'h00_02_00; rx_enable_i = 3'b010;
    send_byte(1, 8'h11);
    sample_en_i = 1;
    for (int k = 0; k < 7; k++) tick();
    chk("R6 not yet", {29'h0, frame_done_o}, 32'h0);
    tick();
    chk("R6 pulse", {29'h0, frame_done_o}, 32'h2);
    tick();
    chk("R6 one cycle", {29'h0, frame_done_o}, 32'h0);
    clr_valid_i[1] = 1; tick(); clr_valid_i[1] = 0;
    repeat (16) tick();
    chk("R6 stopped", {31'h0, status_o[25]}, 32'h0);
    sample_en_i = 0;
    rx_enable_i = 0; tick();

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if (i % 400 == 0)
        frame_len_i = {8'($urandom % 6), 8'($urandom % 12), 8'(($urandom % 3 == 0) ? 0 : $urandom % 20)};
      for (int c = 0; c < NCH; c++) begin
        rx_enable_i[c] = ($urandom % 80) != 0;
        clr_valid_i[c] = ($urandom % 10) == 0;
        clr_ovf_i[c]   = ($urandom % 20) == 0;
      end
      rx_line_i   = 3'($urandom);
      sample_en_i = ($urandom % 4) != 0;
      tx_active_i = ($urandom % 8) == 0;
      tx_lane_i   = 24'($urandom);
      #1;
      compare_all();
      tick();
    end
    compare_all();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule